// File: doc/BRIEF.md
# Cascaded Biquad Parametric Equalizer

This block filters signed audio samples for several interleaved channels. Each sample goes through a pre-gain stage, then a run-time selectable number of second-order (biquad) sections in series, then a post-gain stage. Every stage has its own coefficients and its own arithmetic right-shift, so the fixed-point scaling of each stage can be set on its own. All coefficients and shifts sit in two small memories that a host fills through simple write ports. The filter history is kept separately for each channel and each section, so channels can be interleaved sample by sample.

One shared multiplier does the work. A sample is accepted on a valid/ready handshake, processed one product per clock, and offered on an output valid/ready handshake. Only one sample is in flight at a time. A pass-through mode sends samples through unchanged with the same timing and clears all filter history.

Top module: `cascade_eq`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Gain memory word `ch*62 + i` holds channel `ch`'s entry `i`. Entry 0 is the pre-gain, entry `1+5*s+t` is tap `t` of section `s`, and entry 61 is the post-gain. Taps t=0..4 weight x[n], x[n-1], x[n-2], y[n-1] and y[n-2], in that order. Shift memory word `ch*14 + j` holds the pre-shift (j=0), the shift of section s (j=1+s) or the post-shift (j=13).
- R3: Each active section outputs sat((c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·y[n-1] + c4·y[n-2]) >>> shift). The sum is exact and the shift is arithmetic.
- R4: The pre-gain stage outputs sat((g·x) >>> shift) using entry 0, and the post-gain stage does the same using entry 61. Each uses its own shift.
- R5: Every stage result saturates to the signed `DATA_W` range [-32768, 32767].
- R6: The number of active sections is `cfg_nsec_m1 + 1`, and values above 11 mean 12. Sections beyond the active count are skipped and their history is left untouched.
- R7: Filter history is separate for each (channel, section) pair. Samples of one channel do not change another channel's results. `out_chan` returns the channel of the sample.
- R8: With `cfg_enable` low when a sample is accepted, `out_data` equals the input sample, and the latency is the same as in active mode.
- R9: While `cfg_enable` is low, all filter history is cleared. After the block is re-enabled, filtering starts from zero history.
- R10: `out_valid` rises exactly 2 + 5·N clock edges after the accepting edge, where N is the active section count.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold. The edge that completes the output handshake returns `in_ready` to 1.
- R12: From the accepting edge until the output is taken, `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 = filter, 0 = pass-through and clear history |
| cfg_nsec_m1 | input | 4 | Active sections minus one, sampled at acceptance |
| gain_we | input | 1 | Gain memory write strobe |
| gain_addr | input | 9 | Gain memory word address |
| gain_wdata | input | 32 | Signed gain/coefficient value |
| shift_we | input | 1 | Shift memory write strobe |
| shift_addr | input | 7 | Shift memory word address |
| shift_wdata | input | 5 | Right-shift amount |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block idle, can accept a sample |
| in_chan | input | 3 | Channel of the input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_chan | output | 3 | Channel of the output sample |
| out_data | output | 16 | Signed output sample |

## Verification
Identity coefficients on all sections show that the sequencing and addressing work without any arithmetic effect. Mixed feedforward/feedback coefficients on interleaved channels separate correct per-channel history from shared or swapped history. Pure-delay taps (x[n-2] only) tell which delay slot each tap reads. Extreme inputs and a negative pre-gain reach both saturation limits. Changing the section count shows that skipped sections keep their history. A count above the maximum shows the clamp through latency. Pass-through with non-trivial coefficients, followed by re-enabling, separates echo-and-clear behaviour from filtering with stale history. A stalled output shows the hold behaviour.

// File: rtl/cascade_eq_pkg.sv
`timescale 1ns/1ps
package cascade_eq_pkg;
   localparam int TAPS = 5;
   typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_SEC, PH_POST, PH_OUT} eq_phase_e;
endpackage

// File: rtl/cascade_eq_coef.sv
`timescale 1ns/1ps
// Gain/coefficient and shift memories: synchronous write, asynchronous read.
module cascade_eq_coef #(
   parameter int GDEPTH  = 496,
   parameter int SDEPTH  = 112,
   parameter int COEF_W  = 32,
   parameter int SHIFT_W = 5,
   parameter int GA_W    = 9,
   parameter int SA_W    = 7
) (
   input  logic               clk,
   input  logic               g_we,
   input  logic [GA_W-1:0]    g_waddr,
   input  logic [COEF_W-1:0]  g_wdata,
   input  logic               s_we,
   input  logic [SA_W-1:0]    s_waddr,
   input  logic [SHIFT_W-1:0] s_wdata,
   input  logic [GA_W-1:0]    g_raddr,
   input  logic [SA_W-1:0]    s_raddr,
   output logic [COEF_W-1:0]  g_rdata,
   output logic [SHIFT_W-1:0] s_rdata
);
   localparam logic [GA_W-1:0] G_LAST = GA_W'(GDEPTH - 1);
   localparam logic [SA_W-1:0] S_LAST = SA_W'(SDEPTH - 1);

   logic [COEF_W-1:0]  gmem [GDEPTH];
   logic [SHIFT_W-1:0] smem [SDEPTH];

   always_ff @(posedge clk) begin
      if (g_we && g_waddr <= G_LAST) gmem[g_waddr] <= g_wdata;
      if (s_we && s_waddr <= S_LAST) smem[s_waddr] <= s_wdata;
   end

   assign g_rdata = gmem[g_raddr];
   assign s_rdata = smem[s_raddr];
endmodule

// File: rtl/cascade_eq_state.sv
`timescale 1ns/1ps
// Per (channel, section) delay history, packed {y2, y1, x2, x1}.
module cascade_eq_state #(
   parameter int DEPTH  = 96,
   parameter int DATA_W = 16,
   parameter int ST_W   = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  we,
   input  logic [ST_W-1:0]       waddr,
   input  logic [4*DATA_W-1:0]   wdata,
   input  logic [ST_W-1:0]       raddr,
   output logic [4*DATA_W-1:0]   rdata
);
   logic [4*DATA_W-1:0] hist [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) hist[e] <= '0;
      end else if (clr) begin
         for (int e = 0; e < DEPTH; e++) hist[e] <= '0;
      end else if (we) begin
         hist[waddr] <= wdata;
      end
   end

   assign rdata = hist[raddr];
endmodule

// File: rtl/cascade_eq_mac.sv
`timescale 1ns/1ps
// One multiply per cycle into a wide accumulator; shift and saturate the running sum.
module cascade_eq_mac #(
   parameter int DATA_W  = 16,
   parameter int COEF_W  = 32,
   parameter int SHIFT_W = 5,
   parameter int ACC_W   = 51
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      first,
   input  logic signed [COEF_W-1:0]  coef,
   input  logic signed [DATA_W-1:0]  opnd,
   input  logic [SHIFT_W-1:0]        shamt,
   output logic signed [DATA_W-1:0]  res
);
   localparam int PW = COEF_W + DATA_W;
   localparam logic signed [ACC_W-1:0] MAXV =
      {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] acc_q, acc_d, shifted;

   assign prod    = $signed(PW'(coef)) * $signed(PW'(opnd));
   assign acc_d   = (first ? '0 : acc_q) + ACC_W'(prod);
   assign shifted = acc_d >>> shamt;

   always_comb begin
      if (shifted > MAXV)      res = MAXV[DATA_W-1:0];
      else if (shifted < MINV) res = MINV[DATA_W-1:0];
      else                     res = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= acc_d;
   end
endmodule

// File: rtl/cascade_eq.sv
`timescale 1ns/1ps
module cascade_eq import cascade_eq_pkg::*; #(
   parameter int NCH     = 8,
   parameter int NSEC    = 12,
   parameter int DATA_W  = 16,
   parameter int COEF_W  = 32,
   parameter int SHIFT_W = 5,
   localparam int GPC    = 2 + TAPS * NSEC,
   localparam int SPC    = NSEC + 2,
   localparam int CH_W   = $clog2(NCH),
   localparam int SEC_W  = $clog2(NSEC),
   localparam int GA_W   = $clog2(NCH * GPC),
   localparam int SA_W   = $clog2(NCH * SPC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_enable,
   input  logic [SEC_W-1:0]          cfg_nsec_m1,
   input  logic                      gain_we,
   input  logic [GA_W-1:0]           gain_addr,
   input  logic [COEF_W-1:0]         gain_wdata,
   input  logic                      shift_we,
   input  logic [SA_W-1:0]           shift_addr,
   input  logic [SHIFT_W-1:0]        shift_wdata,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [CH_W-1:0]           in_chan,
   input  logic signed [DATA_W-1:0]  in_data,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [CH_W-1:0]           out_chan,
   output logic signed [DATA_W-1:0]  out_data
);
   localparam int ST_W  = $clog2(NCH * NSEC);
   localparam int ACC_W = COEF_W + DATA_W + 3;

   if (NCH < 2)                     begin : g_chk_nch  $error("NCH must be at least 2");       end
   if (NSEC < 2)                    begin : g_chk_nsec $error("NSEC must be at least 2");      end
   if (DATA_W < 2 || COEF_W < 2)    begin : g_chk_w    $error("data/coef width too small");    end
   if (SHIFT_W < 1 || SHIFT_W > 6)  begin : g_chk_sh   $error("SHIFT_W must be 1..6");         end

   eq_phase_e               phase_q;
   logic [CH_W-1:0]         chan_q;
   logic [SEC_W-1:0]        sec_q, nlast_q, nsec_clamped;
   logic [2:0]              tap_q;
   logic                    byp_q;
   logic signed [DATA_W-1:0] cur_q, opnd, mac_res;
   int                      gi, si;

   logic [COEF_W-1:0]       g_rd;
   logic [SHIFT_W-1:0]      s_rd;
   logic [4*DATA_W-1:0]     st_rd, st_wd;
   logic signed [DATA_W-1:0] h_x1, h_x2, h_y1, h_y2;
   logic                    mac_en, mac_first, st_we, last_tap;
   logic [ST_W-1:0]         st_addr;
   logic [GA_W-1:0]         g_raddr;
   logic [SA_W-1:0]         s_raddr;

   assign nsec_clamped = (int'(cfg_nsec_m1) > NSEC - 1) ? SEC_W'(NSEC - 1) : cfg_nsec_m1;
   assign last_tap     = (tap_q == 3'(TAPS - 1));

   assign h_x1 = st_rd[DATA_W-1:0];
   assign h_x2 = st_rd[2*DATA_W-1:DATA_W];
   assign h_y1 = st_rd[3*DATA_W-1:2*DATA_W];
   assign h_y2 = st_rd[4*DATA_W-1:3*DATA_W];

   always_comb begin
      gi   = 0;
      si   = 0;
      opnd = cur_q;
      case (phase_q)
         PH_SEC: begin
            gi = 1 + TAPS * int'(sec_q) + int'(tap_q);
            si = 1 + int'(sec_q);
            case (tap_q)
               3'd1:    opnd = h_x1;
               3'd2:    opnd = h_x2;
               3'd3:    opnd = h_y1;
               3'd4:    opnd = h_y2;
               default: opnd = cur_q;
            endcase
         end
         PH_POST: begin
            gi = GPC - 1;
            si = SPC - 1;
         end
         default: ;
      endcase
   end

   assign g_raddr   = GA_W'(int'(chan_q) * GPC + gi);
   assign s_raddr   = SA_W'(int'(chan_q) * SPC + si);
   assign st_addr   = ST_W'(int'(chan_q) * NSEC + int'(sec_q));
   assign mac_en    = !byp_q && (phase_q == PH_PRE || phase_q == PH_SEC || phase_q == PH_POST);
   assign mac_first = (phase_q != PH_SEC) || (tap_q == 3'd0);
   assign st_we     = (phase_q == PH_SEC) && last_tap && !byp_q;
   assign st_wd     = {h_y1, mac_res, h_x1, cur_q};

   cascade_eq_coef #(
      .GDEPTH(NCH * GPC), .SDEPTH(NCH * SPC), .COEF_W(COEF_W),
      .SHIFT_W(SHIFT_W), .GA_W(GA_W), .SA_W(SA_W)
   ) u_coef (
      .clk(clk),
      .g_we(gain_we), .g_waddr(gain_addr), .g_wdata(gain_wdata),
      .s_we(shift_we), .s_waddr(shift_addr), .s_wdata(shift_wdata),
      .g_raddr(g_raddr), .s_raddr(s_raddr),
      .g_rdata(g_rd), .s_rdata(s_rd)
   );

   cascade_eq_state #(.DEPTH(NCH * NSEC), .DATA_W(DATA_W), .ST_W(ST_W)) u_state (
      .clk(clk), .rst_n(rst_n), .clr(!cfg_enable),
      .we(st_we), .waddr(st_addr), .wdata(st_wd),
      .raddr(st_addr), .rdata(st_rd)
   );

   cascade_eq_mac #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
      .coef($signed(g_rd)), .opnd(opnd), .shamt(s_rd), .res(mac_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         chan_q  <= '0;
         sec_q   <= '0;
         nlast_q <= '0;
         tap_q   <= '0;
         byp_q   <= 1'b0;
         cur_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (in_valid) begin
               chan_q  <= in_chan;
               cur_q   <= in_data;
               byp_q   <= !cfg_enable;
               nlast_q <= nsec_clamped;
               phase_q <= PH_PRE;
            end
            PH_PRE: begin
               if (!byp_q) cur_q <= mac_res;
               sec_q   <= '0;
               tap_q   <= '0;
               phase_q <= PH_SEC;
            end
            PH_SEC: begin
               if (last_tap) begin
                  if (!byp_q) cur_q <= mac_res;
                  tap_q <= '0;
                  if (sec_q == nlast_q) phase_q <= PH_POST;
                  else                  sec_q   <= sec_q + 1'b1;
               end else begin
                  tap_q <= tap_q + 3'd1;
               end
            end
            PH_POST: begin
               if (!byp_q) cur_q <= mac_res;
               phase_q <= PH_OUT;
            end
            PH_OUT: if (out_ready) phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign in_ready  = (phase_q == PH_IDLE);
   assign out_valid = (phase_q == PH_OUT);
   assign out_data  = cur_q;
   assign out_chan  = chan_q;
endmodule

// File: rtl/cascade_eq_chk.sv
`timescale 1ns/1ps
module cascade_eq_chk #(
   parameter int NCH    = 8,
   parameter int NSEC   = 12,
   parameter int DATA_W = 16,
   localparam int CH_W  = $clog2(NCH),
   localparam int SEC_W = $clog2(NSEC)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_enable,
   input logic [SEC_W-1:0]          cfg_nsec_m1,
   input logic                      in_valid,
   input logic                      in_ready,
   input logic signed [DATA_W-1:0]  in_data,
   input logic                      out_valid,
   input logic                      out_ready,
   input logic [CH_W-1:0]           out_chan,
   input logic signed [DATA_W-1:0]  out_data
);
   logic signed [DATA_W-1:0] cap_data;
   logic                     cap_byp;
   int                       cap_lat, cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_data <= '0;
         cap_byp  <= 1'b0;
         cap_lat  <= 0;
         cnt      <= 0;
      end else if (in_valid && in_ready) begin
         cap_data <= in_data;
         cap_byp  <= !cfg_enable;
         cap_lat  <= 2 + 5 * ((int'(cfg_nsec_m1) > NSEC - 1) ? NSEC : int'(cfg_nsec_m1) + 1);
         cnt      <= 0;
      end else if (!in_ready && !out_valid) begin
         cnt <= cnt + 1;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan)); // R11
   AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> in_ready && !out_valid); // R11
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> !in_ready && !out_valid); // R12
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> cnt == cap_lat); // R10
   AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) && cap_byp |-> out_data == cap_data); // R8
endmodule

bind cascade_eq cascade_eq_chk #(.NCH(NCH), .NSEC(NSEC), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_nsec_m1(cfg_nsec_m1),
   .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
   .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data)
);

// File: tb/cascade_eq_tb.sv
`timescale 1ns/1ps
module cascade_eq_tb;
   localparam int NCH = 8, NSEC = 12, GPC = 62, SPC = 14;
   localparam int DMAX = 32767, DMIN = -32768;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_enable = 1'b0;
   logic [3:0] cfg_nsec_m1 = 4'd0;
   logic gain_we = 1'b0, shift_we = 1'b0;
   logic [8:0] gain_addr = '0;
   logic [31:0] gain_wdata = '0;
   logic [6:0] shift_addr = '0;
   logic [4:0] shift_wdata = '0;
   logic in_valid = 1'b0, out_ready = 1'b1;
   logic [2:0] in_chan = '0;
   logic signed [15:0] in_data = '0;
   logic in_ready, out_valid;
   logic [2:0] out_chan;
   logic signed [15:0] out_data;

   always #4 clk = ~clk;

   cascade_eq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_nsec_m1(cfg_nsec_m1),
      .gain_we(gain_we), .gain_addr(gain_addr), .gain_wdata(gain_wdata),
      .shift_we(shift_we), .shift_addr(shift_addr), .shift_wdata(shift_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data)
   );

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   // reference model state
   int gm [NCH*GPC];
   int sm [NCH*SPC];
   int mx1 [NCH][NSEC];
   int mx2 [NCH][NSEC];
   int my1 [NCH][NSEC];
   int my2 [NCH][NSEC];
   bit m_en = 1'b0;
   int m_nm1 = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int sat(longint v);
      if (v > DMAX) return DMAX;
      if (v < DMIN) return DMIN;
      return int'(v);
   endfunction

   function automatic int n_active();
      return (m_nm1 > NSEC - 1) ? NSEC : m_nm1 + 1;
   endfunction

   function automatic int run_model(int ch, int x);
      int v, y;
      longint acc;
      if (!m_en) return x;
      v = sat((longint'(gm[ch*GPC]) * x) >>> sm[ch*SPC]);
      for (int s = 0; s < n_active(); s++) begin
         int b = ch*GPC + 1 + 5*s;
         acc = longint'(gm[b]) * v + longint'(gm[b+1]) * mx1[ch][s]
             + longint'(gm[b+2]) * mx2[ch][s] + longint'(gm[b+3]) * my1[ch][s]
             + longint'(gm[b+4]) * my2[ch][s];
         y = sat(acc >>> sm[ch*SPC + 1 + s]);
         mx2[ch][s] = mx1[ch][s]; mx1[ch][s] = v;
         my2[ch][s] = my1[ch][s]; my1[ch][s] = y;
         v = y;
      end
      return sat((longint'(gm[ch*GPC + GPC - 1]) * v) >>> sm[ch*SPC + SPC - 1]);
   endfunction

   task automatic wr_gain(input int ch, input int idx, input int val);
      @(negedge clk);
      gain_we = 1'b1; gain_addr = 9'(ch*GPC + idx); gain_wdata = val;
      gm[ch*GPC + idx] = val;
      @(negedge clk);
      gain_we = 1'b0;
   endtask

   task automatic wr_shift(input int ch, input int idx, input int val);
      @(negedge clk);
      shift_we = 1'b1; shift_addr = 7'(ch*SPC + idx); shift_wdata = 5'(val);
      sm[ch*SPC + idx] = val;
      @(negedge clk);
      shift_we = 1'b0;
   endtask

   task automatic program_identity(input int ch);
      wr_gain(ch, 0, 1); wr_shift(ch, 0, 0);
      for (int s = 0; s < NSEC; s++) begin
         wr_gain(ch, 1 + 5*s, 1);
         for (int t = 1; t < 5; t++) wr_gain(ch, 1 + 5*s + t, 0);
         wr_shift(ch, 1 + s, 0);
      end
      wr_gain(ch, GPC - 1, 1); wr_shift(ch, SPC - 1, 0);
   endtask

   task automatic set_cfg(input bit en, input int nm1);
      @(negedge clk);
      cfg_enable = en; cfg_nsec_m1 = 4'(nm1);
      m_en = en; m_nm1 = nm1;
      if (!en)
         for (int c = 0; c < NCH; c++)
            for (int s = 0; s < NSEC; s++) begin
               mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
            end
      @(negedge clk);
   endtask

   // Sends one sample, checks every cycle until the output is taken.
   task automatic send(input int ch, input int x, input int hold, input string req);
      int exp, lat;
      exp = run_model(ch, x);
      lat = 2 + 5 * n_active();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_chan = 3'(ch); in_data = 16'(x);
      out_ready = (hold == 0);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         if (k < lat) begin
            chk(!out_valid && !in_ready, "R12", "busy before latency", longint'(out_valid), 0);
         end else begin
            chk(out_valid, "R10", "out_valid at latency", longint'(out_valid), 1);
            chk(out_data == exp, req, "out_data", longint'(out_data), exp);
            chk(int'(out_chan) == ch, "R7", "out_chan", longint'(out_chan), ch);
         end
      end
      if (hold > 0) begin
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && out_data == exp, "R11", "hold under stall", longint'(out_data), exp);
         end
         out_ready = 1'b1;
         @(negedge clk);
         chk(!out_valid && in_ready, "R11", "ready after take", longint'(in_ready), 1);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NSEC; s++) begin
            mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
         end
      repeat (3) @(negedge clk);
      chk(in_ready && !out_valid, "R1", "during reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready, "R1", "in_ready after reset", longint'(in_ready), 1);
      chk(!out_valid, "R1", "out_valid after reset", longint'(out_valid), 0);

      for (int c = 0; c < 4; c++) program_identity(c);

      // R3 identity chain across extremes
      set_cfg(1'b1, 2);
      send(0, 100, 0, "R3");
      send(0, -5, 0, "R3");
      send(0, 32767, 0, "R3");
      send(0, -32768, 0, "R3");

      // R4 R5 R3: gains, feedforward and feedback on channel 1
      wr_gain(1, 0, 3);  wr_shift(1, 0, 1);
      wr_gain(1, 1, 2);  wr_gain(1, 2, 1);  wr_shift(1, 1, 1);
      wr_gain(1, 9, 1);  wr_shift(1, 2, 1);
      wr_gain(1, GPC - 1, 5); wr_shift(1, SPC - 1, 2);
      // R2: channel 2 uses only the x[n-2] tap of section 0 and a negative pre-gain
      wr_gain(2, 0, -1);
      wr_gain(2, 1, 0);  wr_gain(2, 3, 1);
      send(1, 1000, 0, "R4");
      send(2, 700, 0, "R2");
      send(1, -2000, 0, "R3");
      send(0, 55, 0, "R7");
      send(2, -32768, 0, "R5");
      send(1, 30000, 0, "R5");
      send(2, 9, 0, "R2");
      send(1, -30000, 0, "R5");
      send(2, 11, 0, "R2");
      send(1, 123, 0, "R7");

      // R6: skipped section keeps its history
      wr_gain(3, 6, 1); wr_gain(3, 7, 1);
      set_cfg(1'b1, 0);
      send(3, 10, 0, "R6");
      send(3, 20, 0, "R6");
      set_cfg(1'b1, 1);
      send(3, 40, 0, "R6");
      send(3, 50, 0, "R6");
      // R6 clamp above maximum count
      set_cfg(1'b1, 15);
      send(0, -1234, 0, "R6");

      // R8: pass-through with nontrivial coefficients
      set_cfg(1'b0, 4);
      send(1, 1234, 0, "R8");
      send(1, -777, 0, "R8");
      send(2, 32767, 0, "R8");
      // R9: history restarts from zero
      set_cfg(1'b1, 2);
      send(1, 500, 0, "R9");
      send(2, 321, 0, "R9");
      send(1, 600, 0, "R9");

      // R11 stalled output
      send(1, -400, 4, "R11");
      send(0, 77, 2, "R11");

      finish_run();
   end
endmodule